// File: doc/BRIEF.md
# Oscillator Delay-Stage Search Controller

This block tunes a digitally controlled ring oscillator to its target frequency. Once per reference period a time-to-digital converter reports how far the oscillator is from target, as an error magnitude in counted pulses and a direction flag. The controller picks a coarse tap and then a fine tap of the oscillator's two delay lines. Both are driven as one-hot selects. When the loop has settled it powers down every delay cell past the chosen taps and sleeps. The intended operating point is an output ten times the reference, for example 500 kHz from a 50 kHz reference.

The search is not a plain halving search. Each move is sized from the error just measured: the error shifted right by a per-phase amount, clamped to the ends of the line. The first measurement after a start therefore places the tap directly, in proportion to how far off the oscillator is. The coarse line is settled first and then the fine line. Lock is declared after two consecutive in-tolerance readings. The controller then freezes and gates off unused cells. It leaves sleep when a wake input is pulsed or when a reading falls out of tolerance.

Top module: `dco_search_ctrl`

## Requirements
- R1: After reset the coarse and fine selects both equal 12'h001 (position 0), both enable masks are 12'hFFF and `locked` is low.
- R2: Each select is a 12-bit one-hot code; bit k set means tap position k (k delay stages plus one) is chosen, and the code changes only as a result of a measurement.
- R3: In the coarse phase a measurement moves the coarse position by `tdc_err >> 5`, upward (more delay) when `tdc_lead` is 1 and downward when it is 0, saturating at 0 and 11.
- R4: The coarse phase ends, with the coarse position left unchanged, on the first measurement whose coarse step is zero or whose saturated move would leave the position where it is; the next measurement is handled by the fine phase.
- R5: In the fine phase an out-of-tolerance measurement (`tdc_err > tol`) moves the fine position by the larger of 1 and `tdc_err >> 2`, in the direction given by `tdc_lead`, saturating at 0 and 11.
- R6: In the fine phase `locked` rises after two consecutive measurements with `tdc_err <= tol`; an out-of-tolerance measurement between them restarts that count.
- R7: While searching both enable masks are all ones; while locked each mask has bits 0 up to the selected position set and all higher bits clear.
- R8: While locked, an in-tolerance measurement changes no output.
- R9: While locked, an out-of-tolerance measurement clears `locked`, restores all-ones masks and restarts the coarse phase from the held positions, without moving them.
- R10: A `wake` pulse clears `locked`, restores all-ones masks and restarts the coarse phase from the held positions; a measurement in the same cycle is discarded.
- R11: With an oscillator whose count falls by 30 per coarse stage and 3 per fine stage, lock is reached in fewer than 10 measurements from a start.
- R12: Without `meas_valid` or `wake`, all outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| meas_valid | input | 1 | One-cycle strobe: a new error reading is present |
| tdc_err | input | 9 | Error magnitude in counted pulses |
| tdc_lead | input | 1 | 1: oscillator fast, add delay; 0: oscillator slow |
| tol | input | 9 | Lock tolerance in pulses |
| wake | input | 1 | One-cycle request to leave sleep and search again |
| coarse_sel | output | 12 | One-hot coarse tap select |
| fine_sel | output | 12 | One-hot fine tap select |
| coarse_en | output | 12 | Coarse delay-cell power enables |
| fine_en | output | 12 | Fine delay-cell power enables |
| locked | output | 1 | High while locked and asleep |

## Verification
A wake pulse and an error reading can land in the same clock. The bench provokes this twice: once while asleep with an in-tolerance reading, and once during a fine search with an out-of-tolerance reading that would otherwise move the fine tap. Both times the scoreboard expects the restart to win and the reading to be dropped. The selects must stay put, `locked` must be low and the masks all ones. The following readings must then re-lock from the held taps.

// File: rtl/dco_search_ctrl.sv
`timescale 1ns/1ps
module dco_search_ctrl #(
  parameter int NS  = 12,
  parameter int CW  = 9,
  parameter int CSH = 5,
  parameter int FSH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          meas_valid,
  input  logic [CW-1:0] tdc_err,
  input  logic          tdc_lead,
  input  logic [CW-1:0] tol,
  input  logic          wake,
  output logic [NS-1:0] coarse_sel,
  output logic [NS-1:0] fine_sel,
  output logic [NS-1:0] coarse_en,
  output logic [NS-1:0] fine_en,
  output logic          locked
);
  localparam int PW = $clog2(NS);
  localparam logic [CW:0] TOP = (CW+1)'(NS-1);

  typedef enum logic [1:0] {PH_COARSE, PH_FINE, PH_SLEEP} phase_t;

  phase_t        ph;
  logic [PW-1:0] cpos, fpos;
  logic          hit;

  function automatic logic [PW-1:0] move(input logic [PW-1:0] p, input logic [CW-1:0] s, input logic up);
    logic [CW:0] w;
    logic [CW:0] pw;
    pw = {{(CW+1-PW){1'b0}}, p};
    if (up) begin
      w = pw + {1'b0, s};
      return (w > TOP) ? TOP[PW-1:0] : w[PW-1:0];
    end
    return ({1'b0, s} >= pw) ? '0 : p - s[PW-1:0];
  endfunction

  wire            in_tol = (tdc_err <= tol);
  wire [CW-1:0]   cstep  = tdc_err >> CSH;
  wire [CW-1:0]   fraw   = tdc_err >> FSH;
  wire [CW-1:0]   fstep  = (fraw == '0) ? CW'(1) : fraw;
  wire [PW-1:0]   c_nxt  = move(cpos, cstep, tdc_lead);
  wire [PW-1:0]   f_nxt  = move(fpos, fstep, tdc_lead);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph   <= PH_COARSE;
      cpos <= '0;
      fpos <= '0;
      hit  <= 1'b0;
    end else if (wake) begin
      ph  <= PH_COARSE;
      hit <= 1'b0;
    end else if (meas_valid) begin
      case (ph)
        PH_COARSE: begin
          if (cstep == '0 || c_nxt == cpos) ph <= PH_FINE;
          else cpos <= c_nxt;
        end
        PH_FINE: begin
          if (in_tol) begin
            if (hit) ph <= PH_SLEEP;
            hit <= 1'b1;
          end else begin
            hit  <= 1'b0;
            fpos <= f_nxt;
          end
        end
        PH_SLEEP: begin
          if (!in_tol) begin
            ph  <= PH_COARSE;
            hit <= 1'b0;
          end
        end
        default: ph <= PH_COARSE;
      endcase
    end
  end

  assign coarse_sel = NS'(1) << cpos;
  assign fine_sel   = NS'(1) << fpos;
  assign locked     = (ph == PH_SLEEP);
  assign coarse_en  = locked ? ((coarse_sel << 1) - NS'(1)) : '1;
  assign fine_en    = locked ? ((fine_sel << 1) - NS'(1)) : '1;
endmodule

module dco_search_chk #(
  parameter int NS = 12,
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          meas_valid,
  input logic [CW-1:0] tdc_err,
  input logic [CW-1:0] tol,
  input logic          wake,
  input logic [NS-1:0] coarse_sel,
  input logic [NS-1:0] fine_sel,
  input logic [NS-1:0] coarse_en,
  input logic [NS-1:0] fine_en,
  input logic          locked
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(coarse_sel) == 1 && $countones(fine_sel) == 1);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!meas_valid && !wake) |=> ($stable(coarse_sel) && $stable(fine_sel) && $stable(locked)));

  p_search_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (&coarse_en && &fine_en));

  p_sleep_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (((coarse_en + NS'(1)) & coarse_en) == '0 && (coarse_en & coarse_sel) == coarse_sel
                && ((coarse_en >> 1) & coarse_sel) == '0));

  p_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (!locked && $stable(coarse_sel) && $stable(fine_sel)));

  p_sleep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && meas_valid && !wake && tdc_err <= tol) |=> (locked && $stable(coarse_sel) && $stable(fine_sel)));

  p_lock_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> ($past(meas_valid) && $past(tdc_err <= tol) && !$past(wake)));
endmodule

bind dco_search_ctrl dco_search_chk #(.NS(NS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .tdc_err(tdc_err), .tol(tol),
  .wake(wake), .coarse_sel(coarse_sel), .fine_sel(fine_sel), .coarse_en(coarse_en),
  .fine_en(fine_en), .locked(locked));

// File: tb/dco_search_ctrl_test.sv
`timescale 1ns/1ps
module dco_search_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        meas_valid = 1'b0;
  logic [8:0]  tdc_err = '0;
  logic        tdc_lead = 1'b0;
  logic [8:0]  tol = 9'd2;
  logic        wake = 1'b0;
  logic [11:0] coarse_sel, fine_sel, coarse_en, fine_en;
  logic        locked;

  always #2.5 clk = ~clk;

  dco_search_ctrl uut (
    .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .tdc_err(tdc_err),
    .tdc_lead(tdc_lead), .tol(tol), .wake(wake), .coarse_sel(coarse_sel),
    .fine_sel(fine_sel), .coarse_en(coarse_en), .fine_en(fine_en), .locked(locked));

  typedef struct {
    logic [11:0] cs, fs, ce, fe;
    logic        lk;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  int mc = 0, mf = 0, mph = 0, mhit = 0;
  int tgt = 200;

  task automatic chk(input string r, input logic [31:0] a, input logic [31:0] x);
    checks++;
    if (a !== x) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, a, x);
    end
  endtask

  function automatic logic [11:0] thermo(input int p);
    return 12'((1 << (p + 1)) - 1);
  endfunction

  function automatic exp_t expect_now(input string tag);
    exp_t e;
    e.cs = 12'(1 << mc);
    e.fs = 12'(1 << mf);
    e.lk = (mph == 2);
    e.ce = (mph == 2) ? thermo(mc) : 12'hFFF;
    e.fe = (mph == 2) ? thermo(mf) : 12'hFFF;
    e.tag = tag;
    return e;
  endfunction

  function automatic int sat_move(input int p, input int s, input bit up);
    int n;
    n = up ? p + s : p - s;
    if (n > 11) n = 11;
    if (n < 0) n = 0;
    return n;
  endfunction

  task automatic model(input int err, input bit lead, input bit v, input bit wk);
    int st, nx;
    if (wk) begin
      mph = 0; mhit = 0;
    end else if (v) begin
      case (mph)
        0: begin
          st = err >> 5;
          nx = sat_move(mc, st, lead);
          if (st == 0 || nx == mc) mph = 1; else mc = nx;
        end
        1: begin
          if (err <= int'(tol)) begin
            if (mhit != 0) mph = 2;
            mhit = 1;
          end else begin
            mhit = 0;
            st = err >> 2;
            if (st == 0) st = 1;
            mf = sat_move(mf, st, lead);
          end
        end
        default: if (err > int'(tol)) begin mph = 0; mhit = 0; end
      endcase
    end
  endtask

  task automatic meas(input int err, input bit lead, input bit v, input bit wk, input string tag);
    @(negedge clk);
    tdc_err = 9'(err); tdc_lead = lead; meas_valid = v; wake = wk;
    model(err, lead, v, wk);
    q.push_back(expect_now(tag));
    @(negedge clk);
    meas_valid = 1'b0; wake = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic osc_meas(input string tag);
    int o, e;
    o = 400 - 30 * mc - 3 * mf;
    e = (o > tgt) ? o - tgt : tgt - o;
    meas(e, o > tgt, 1'b1, 1'b0, tag);
  endtask

  task automatic run_to_lock(input string tag);
    int n = 0;
    while (mph != 2 && n < 20) begin
      osc_meas(tag);
      n++;
    end
    chk("R11 measurements to lock below 10", 32'(n < 10), 32'd1);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk);
      if (meas_valid || wake) begin
        #1;
        if (q.size() == 0) begin
          chk("R2 scoreboard underflow", 32'd1, 32'd0);
        end else begin
          e = q.pop_front();
          chk({e.tag, " coarse_sel"}, 32'(coarse_sel), 32'(e.cs));
          chk({e.tag, " fine_sel"},   32'(fine_sel),   32'(e.fs));
          chk({e.tag, " coarse_en R7"}, 32'(coarse_en), 32'(e.ce));
          chk({e.tag, " fine_en R7"},   32'(fine_en),   32'(e.fe));
          chk({e.tag, " locked"},     32'(locked),     32'(e.lk));
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [11:0] cs0, fs0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset coarse_sel", 32'(coarse_sel), 32'h001);
    chk("R1 reset fine_sel", 32'(fine_sel), 32'h001);
    chk("R1 reset coarse_en", 32'(coarse_en), 32'hFFF);
    chk("R1 reset fine_en", 32'(fine_en), 32'hFFF);
    chk("R1 reset locked", 32'(locked), 32'd0);

    // R3 R4 R5 R6: proportional coarse jump, handoff, fine steps, double hit
    tgt = 200; tol = 9'd2;
    run_to_lock("R3 R4 R5 R6 first acquisition");
    chk("R7 locked coarse mask", 32'(coarse_en), 32'h07F);

    // R8: in-tolerance reading while asleep
    meas(1, 1'b0, 1'b1, 1'b0, "R8 sleep in-tol");

    // R9: out-of-tolerance reading wakes the search, then re-lock
    tgt = 160;
    osc_meas("R9 sleep out-of-tol restart");
    chk("R9 locked cleared", 32'(locked), 32'd0);
    run_to_lock("R9 reacquire");

    // R10: wake with coincident in-tolerance reading
    meas(0, 1'b0, 1'b1, 1'b1, "R10 wake with reading in sleep");
    run_to_lock("R10 relock after wake");

    // R10: wake during fine search with a reading that would move fine tap
    meas(0, 1'b0, 1'b0, 1'b1, "R10 wake");
    meas(0, 1'b0, 1'b1, 1'b0, "R4 zero step handoff");
    cs0 = coarse_sel; fs0 = fine_sel;
    meas(40, 1'b1, 1'b1, 1'b1, "R10 wake beats fine move");
    chk("R10 fine tap held", 32'(fine_sel), 32'(fs0));
    chk("R10 coarse tap held", 32'(coarse_sel), 32'(cs0));

    // R6: miss between hits restarts the hit count
    meas(0, 1'b0, 1'b1, 1'b0, "R4 handoff");
    meas(1, 1'b0, 1'b1, 1'b0, "R6 first hit");
    meas(9, 1'b1, 1'b1, 1'b0, "R6 miss moves fine R5");
    meas(0, 1'b0, 1'b1, 1'b0, "R6 hit after miss");
    chk("R6 not locked after broken pair", 32'(locked), 32'd0);
    meas(2, 1'b1, 1'b1, 1'b0, "R6 second hit locks");
    chk("R6 locked", 32'(locked), 32'd1);

    // R3 R4 R5 saturation upward
    meas(0, 1'b0, 1'b0, 1'b1, "R10 wake");
    tgt = 0;
    repeat (5) osc_meas("R3 R4 R5 saturate high");
    chk("R3 coarse at top", 32'(coarse_sel), 32'h800);
    chk("R5 fine at top", 32'(fine_sel), 32'h800);
    // R5 saturation downward
    tgt = 500;
    repeat (2) osc_meas("R5 saturate low");
    chk("R5 fine at bottom", 32'(fine_sel), 32'h001);
    // R3 R4 saturation downward in coarse
    meas(0, 1'b0, 1'b0, 1'b1, "R10 wake");
    repeat (3) osc_meas("R3 R4 saturate low");
    chk("R3 coarse at bottom", 32'(coarse_sel), 32'h001);

    // R12: idle hold
    cs0 = coarse_sel; fs0 = fine_sel;
    repeat (20) @(negedge clk);
    chk("R12 coarse hold", 32'(coarse_sel), 32'(cs0));
    chk("R12 fine hold", 32'(fine_sel), 32'(fs0));
    chk("R12 locked hold", 32'(locked), 32'(mph == 2));

    repeat (4) @(negedge clk);
    chk("R2 scoreboard drained", 32'(q.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule